// File: doc/BRIEF.md
# CSR Row Range Traversal Engine

This block walks a compressed-sparse-row structure on behalf of a decoupled consumer. Row indices enter through an internal input queue. For each index `i`, an offsets stage reads the two words that bound the row from an offsets array in memory. It then hands the half-open range `[start, end)` to a rows stage through a small range queue. The rows stage reads every element in that range in ascending order and places each one in an output queue as a coordinate/value pair. After the last element of the row it places an end-of-row marker.

Both stages share one request/response memory port. Each request carries a word address and a one-bit stage tag. Responses return in request order. The queue between the stages lets the offsets of later rows be fetched while an earlier row is still streaming or is stalled by the consumer. A credit check keeps every returning element within the output queue's capacity. As a result, backpressure never drops data.

Top module: `csr_row_walker`

## Requirements
- R1: During and directly after reset, `out_valid` and `mem_req_valid` are 0 and `in_ready` is 1.
- R2: For row index `i`, the engine issues tag-0 requests to word address `OFFS_BASE+i` and then `OFFS_BASE+i+1`. It takes each offset from response bits [31:0].
- R3: For a range `[s, e)`, the engine issues tag-1 requests to `ROWS_BASE+s` up to `ROWS_BASE+e-1`, in ascending order. It never receives a tag-1 response without a tag-1 request outstanding.
- R4: Each element leaves with `out_eor`=0, `out_coord` equal to response bits [31:0] and `out_value` equal to response bits [63:32].
- R5: After the last element of each row, exactly one beat appears with `out_eor`=1, `out_coord`=0 and `out_value`=0.
- R6: A row whose start equals its end produces only the end-of-row beat.
- R7: Rows leave in the order their indices were accepted, and the input queue never holds more than `IQ_DEPTH` indices.
- R8: With `out_ready` low, the output beat holds stable and nothing is lost. The queue never overflows, and once the queued plus outstanding elements reach `OQ_DEPTH` no further tag-1 request is issued.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request address and tag hold stable.
- R10: While one row is stalled at the output, the offsets of up to `RQ_DEPTH` later rows are still fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row index offered |
| in_ready | output | 1 | Input queue has room |
| in_row | input | 32 | Row index |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Word address |
| mem_req_tag | output | 1 | 0 = offsets stage, 1 = rows stage |
| mem_resp_valid | input | 1 | Read data returned (in request order) |
| mem_resp_data | input | 64 | Read word |
| mem_resp_tag | input | 1 | Tag of the returned request |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Consumer takes beat |
| out_eor | output | 1 | End-of-row marker beat |
| out_coord | output | 32 | Element coordinate |
| out_value | output | 32 | Element value |

## Verification
Assertions check the following on every cycle:
- the output queue never overflows;
- output and request stability hold under backpressure;
- no rows response arrives unrequested;
- the input queue count stays bounded.

Only the bench scenarios can show the rest. This covers address sequences per stage, correct pairing of coordinate and value, and marker placement including empty and single-element rows. It also covers the limit on rows requests during a long consumer stall, and offsets for later rows being fetched while that stall lasts.

// File: rtl/csr_row_walker.sv
module csr_row_walker #(
  parameter logic [31:0] OFFS_BASE = 32'h100,
  parameter logic [31:0] ROWS_BASE = 32'h200,
  parameter int IQ_DEPTH = 4,
  parameter int RQ_DEPTH = 2,
  parameter int OQ_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_row,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  output logic        mem_req_tag,
  input  logic        mem_resp_valid,
  input  logic [63:0] mem_resp_data,
  input  logic        mem_resp_tag,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_eor,
  output logic [31:0] out_coord,
  output logic [31:0] out_value
);
  localparam int IAW = $clog2(IQ_DEPTH);
  localparam int RAW = $clog2(RQ_DEPTH);
  localparam int OAW = $clog2(OQ_DEPTH);
  localparam logic [IAW:0] IQ_N = IQ_DEPTH[IAW:0];
  localparam logic [RAW:0] RQ_N = RQ_DEPTH[RAW:0];
  localparam logic [OAW:0] OQ_N = OQ_DEPTH[OAW:0];

  typedef enum logic [1:0] {O_IDLE, O_LO, O_HI, O_WAIT} ost_t;

  // input queue
  logic [31:0]  iq_mem [IQ_DEPTH];
  logic [IAW-1:0] iq_rp, iq_wp;
  logic [IAW:0] iq_cnt;
  logic iq_push, iq_pop;

  // range queue
  logic [63:0]  rq_mem [RQ_DEPTH];
  logic [RAW-1:0] rq_rp, rq_wp;
  logic [RAW:0] rq_cnt;
  logic rq_push, rq_pop;

  // output queue
  logic [64:0]  oq_mem [OQ_DEPTH];
  logic [OAW-1:0] oq_rp, oq_wp;
  logic [OAW:0] oq_cnt;
  logic oq_push, oq_pop;
  logic [64:0] oq_din;

  // offsets stage
  ost_t        o_st;
  logic [31:0] o_row, o_start, o_end;
  logic [1:0]  o_got;
  logic        offs_req, offs_fire, resp_offs;

  // rows stage
  logic        r_act;
  logic [31:0] r_cur, r_end;
  logic [OAW:0] r_pend;
  logic [OAW+1:0] r_load;
  logic        rows_req, rows_fire, resp_rows, marker, lock_offs;

  assign in_ready  = iq_cnt != IQ_N;
  assign iq_push   = in_valid && in_ready;
  assign iq_pop    = o_st == O_IDLE && iq_cnt != 0 && rq_cnt != RQ_N;

  assign offs_req  = o_st == O_LO || o_st == O_HI;
  assign rq_push   = o_st == O_WAIT && o_got == 2'd2;
  assign rq_pop    = !r_act && rq_cnt != 0;
  assign resp_offs = mem_resp_valid && !mem_resp_tag;
  assign resp_rows = mem_resp_valid && mem_resp_tag;

  assign r_load    = {1'b0, oq_cnt} + {1'b0, r_pend};
  assign rows_req  = r_act && r_cur < r_end && r_load < {1'b0, OQ_N} && !lock_offs;
  assign marker    = r_act && !(r_cur < r_end) && r_pend == 0 && oq_cnt != OQ_N;

  assign mem_req_valid = rows_req || offs_req;
  assign mem_req_tag   = rows_req;
  assign mem_req_addr  = rows_req ? ROWS_BASE + r_cur
                                  : OFFS_BASE + o_row + 32'(o_st == O_HI);
  assign rows_fire = rows_req && mem_req_ready;
  assign offs_fire = !rows_req && offs_req && mem_req_ready;

  assign oq_push = resp_rows || marker;
  assign oq_din  = marker ? {1'b1, 64'd0}
                          : {1'b0, mem_resp_data[31:0], mem_resp_data[63:32]};
  assign out_valid = oq_cnt != 0;
  assign oq_pop    = out_valid && out_ready;
  assign {out_eor, out_coord, out_value} = oq_mem[oq_rp];

  always_ff @(posedge clk) begin
    if (iq_push) iq_mem[iq_wp] <= in_row;
    if (rq_push) rq_mem[rq_wp] <= {o_end, o_start};
    if (oq_push) oq_mem[oq_wp] <= oq_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iq_rp <= '0; iq_wp <= '0; iq_cnt <= '0;
      rq_rp <= '0; rq_wp <= '0; rq_cnt <= '0;
      oq_rp <= '0; oq_wp <= '0; oq_cnt <= '0;
    end else begin
      if (iq_push) iq_wp <= iq_wp + 1'b1;
      if (iq_pop)  iq_rp <= iq_rp + 1'b1;
      iq_cnt <= iq_cnt + (IAW+1)'(iq_push) - (IAW+1)'(iq_pop);
      if (rq_push) rq_wp <= rq_wp + 1'b1;
      if (rq_pop)  rq_rp <= rq_rp + 1'b1;
      rq_cnt <= rq_cnt + (RAW+1)'(rq_push) - (RAW+1)'(rq_pop);
      if (oq_push) oq_wp <= oq_wp + 1'b1;
      if (oq_pop)  oq_rp <= oq_rp + 1'b1;
      oq_cnt <= oq_cnt + (OAW+1)'(oq_push) - (OAW+1)'(oq_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_st <= O_IDLE; o_row <= '0; o_start <= '0; o_end <= '0; o_got <= '0;
    end else begin
      case (o_st)
        O_IDLE: if (iq_pop) begin o_row <= iq_mem[iq_rp]; o_st <= O_LO; end
        O_LO:   if (offs_fire) o_st <= O_HI;
        O_HI:   if (offs_fire) o_st <= O_WAIT;
        O_WAIT: if (rq_push) o_st <= O_IDLE;
        default: o_st <= O_IDLE;
      endcase
      if (rq_push) o_got <= '0;
      else if (resp_offs) begin
        o_got <= o_got + 1'b1;
        if (o_got == 2'd0) o_start <= mem_resp_data[31:0];
        else o_end <= mem_resp_data[31:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_act <= 1'b0; r_cur <= '0; r_end <= '0; r_pend <= '0; lock_offs <= 1'b0;
    end else begin
      lock_offs <= mem_req_valid && !mem_req_ready && !mem_req_tag;
      if (rq_pop) begin
        r_act <= 1'b1;
        r_cur <= rq_mem[rq_rp][31:0];
        r_end <= rq_mem[rq_rp][63:32];
      end else begin
        if (rows_fire) r_cur <= r_cur + 1'b1;
        if (marker) r_act <= 1'b0;
      end
      r_pend <= r_pend + (OAW+1)'(rows_fire) - (OAW+1)'(resp_rows);
    end
  end

  // R8
  oq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oq_push |-> (oq_cnt != OQ_N || oq_pop));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_eor, out_coord, out_value}));
  // R9
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable({mem_req_tag, mem_req_addr}));
  // R3
  rows_resp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_rows |-> r_pend != 0);
  // R7
  iq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iq_cnt <= IQ_N);
endmodule

// File: tb/test_csr_row_walker.sv
`timescale 1ns/1ps
module test_csr_row_walker;
  localparam logic [31:0] OB = 32'h100;
  localparam logic [31:0] RB = 32'h200;
  localparam int OQD = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [31:0] in_row = 0;
  logic mem_req_valid, mem_req_ready = 0, mem_req_tag;
  logic [31:0] mem_req_addr;
  logic mem_resp_valid = 0, mem_resp_tag = 0;
  logic [63:0] mem_resp_data = 0;
  logic out_valid, out_ready = 0, out_eor;
  logic [31:0] out_coord, out_value;

  csr_row_walker #(.OFFS_BASE(OB), .ROWS_BASE(RB), .IQ_DEPTH(4), .RQ_DEPTH(2), .OQ_DEPTH(OQD))
  i_csr_row_walker (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int t0_cnt = 0, t1_cnt = 0;
  bit hold_out = 0, mem_fast = 0, in_acc = 0;
  logic [31:0] offs_tab [7];
  logic [31:0] send_q[$], t0_q[$], t1_q[$];
  logic [64:0] exp_q[$], resp_q[$];
  string lbl_q[$];

  task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_read(input logic [31:0] a);
    logic [31:0] k;
    if (a >= OB && a < OB + 7) return {32'd0, offs_tab[a - OB]};
    k = a - RB;
    return {32'hA000 + k, k * 32'd3 + 32'd1};
  endfunction

  task automatic send_row(input int i);
    logic [31:0] s, e;
    s = offs_tab[i]; e = offs_tab[i+1];
    send_q.push_back(i);
    t0_q.push_back(OB + i); t0_q.push_back(OB + i + 1);
    for (logic [31:0] k = s; k < e; k++) begin
      t1_q.push_back(RB + k);
      exp_q.push_back({1'b0, k * 32'd3 + 32'd1, 32'hA000 + k});
      lbl_q.push_back("R3 R4 R7");
    end
    exp_q.push_back({1'b1, 64'd0});
    lbl_q.push_back(s == e ? "R6" : "R5");
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (resp_q.size() > 0 && (mem_fast || $urandom % 2 == 0)) begin
        {mem_resp_tag, mem_resp_data} = resp_q.pop_front();
        mem_resp_valid = 1;
      end else mem_resp_valid = 0;
      mem_req_ready = mem_fast ? 1'b1 : ($urandom % 3 != 0);
      out_ready = hold_out ? 1'b0 : ($urandom % 4 != 0);
      if (in_valid && in_acc) in_valid = 0;
      if (!in_valid && send_q.size() > 0) begin
        in_valid = 1; in_row = send_q.pop_front();
      end
      #1;
      in_acc = in_valid && in_ready;
      if (mem_req_valid && mem_req_ready) begin
        if (!mem_req_tag) begin
          t0_cnt++;
          if (t0_q.size() == 0) chk(0, "R2 unexpected offsets request", {33'd0, mem_req_addr}, 0);
          else begin
            logic [31:0] ea;
            ea = t0_q.pop_front();
            chk(mem_req_addr == ea, "R2 offsets address", {33'd0, mem_req_addr}, {33'd0, ea});
          end
        end else begin
          t1_cnt++;
          if (t1_q.size() == 0) chk(0, "R3 unexpected rows request", {33'd0, mem_req_addr}, 0);
          else begin
            logic [31:0] ea;
            ea = t1_q.pop_front();
            chk(mem_req_addr == ea, "R3 rows address", {33'd0, mem_req_addr}, {33'd0, ea});
          end
        end
        resp_q.push_back({mem_req_tag, mem_read(mem_req_addr)});
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected output", {out_eor, out_coord, out_value}, 0);
        else begin
          logic [64:0] e;
          string l;
          e = exp_q.pop_front(); l = lbl_q.pop_front();
          chk({out_eor, out_coord, out_value} == e, l, {out_eor, out_coord, out_value}, e);
        end
      end
    end
  end

  task automatic at_neg();
    @(negedge clk); #5;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) at_neg();
    repeat (10) at_neg();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    offs_tab = '{0, 2, 4, 5, 5, 11, 12};
    repeat (4) at_neg();
    chk(!out_valid && !mem_req_valid && in_ready, "R1 in reset",
        {62'd0, out_valid, mem_req_valid, in_ready}, 65'd1);
    rst_n = 1;
    at_neg();
    chk(!out_valid && !mem_req_valid && in_ready, "R1 after reset",
        {62'd0, out_valid, mem_req_valid, in_ready}, 65'd1);
    // rows 0..3: two, two, one, empty
    send_row(0); send_row(1); send_row(2); send_row(3);
    drain();
    // stall phase
    hold_out = 1; mem_fast = 1;
    at_neg();
    t0_cnt = 0; t1_cnt = 0;
    send_row(4); send_row(5); send_row(0);
    repeat (60) at_neg();
    chk(t1_cnt > 0 && t1_cnt <= OQD, "R8 rows requests bounded while stalled", 65'(t1_cnt), 65'(OQD));
    chk(t0_cnt == 6, "R10 later offsets fetched during stall", 65'(t0_cnt), 65'd6);
    chk(out_valid, "R8 output held while stalled", {64'd0, out_valid}, 65'd1);
    hold_out = 0; mem_fast = 0;
    drain();
    for (int n = 0; n < 24; n++) send_row((n * 5 + 3) % 6);
    drain();
    chk(t0_q.size() == 0, "R2 all offsets requests seen", 65'(t0_q.size()), 0);
    chk(t1_q.size() == 0, "R3 all rows requests seen", 65'(t1_q.size()), 0);
    chk(exp_q.size() == 0, "R7 all outputs seen", 65'(exp_q.size()), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule